// File: doc/BRIEF.md
# Register Protection Address Wrapper

This block sits between a bus slave port and a peripheral's register file and gives that register file a 16 KB address window with byte-level write protection. The window is split by offset into five regions. A direct region reaches the registers unchanged. A reserved hole always fails. A mirror region reaches the same registers and, on writes, also arms a soft lock on each byte it writes. A lock region shows the soft lock bits and lets software change them. A configuration region holds a sticky hard lock that freezes the lock region.

The request side is a single-cycle bus: valid, byte address, write enable, four byte enables and 32-bit write data. Byte lane j is `wdata[8j+7:8j]` and maps to register byte 4w+j of register word w. Every request gets a response exactly one cycle later, carrying read data and an error flag. Register accesses are forwarded in the request cycle to the register file. The register file returns read data on the following cycle. Write byte enables for locked bytes are removed before they reach the register file. Lock bits exist only for the register words below `NUM_LOCK_WORDS`, and only for the bytes whose bit is set in `LOCK_MASK`: bit 4w+j covers lane j of word w.

Top module: `regprot_wrap`

## Requirements
- R1: An offset in 0x0000–0x17FF reaches register word offset[12:2], and a read returns that word. Every request with `req_valid` high produces `rsp_valid` high exactly one cycle later, and no response appears otherwise.
- R2: An access at an offset in 0x1800–0x1FFF returns `rsp_err`=1 and read data 0. It makes no register file request and changes no lock bit.
- R3: An offset 0x2000+X accesses the same register word as offset X.
- R4: A write at 0x2000+X sets the soft lock bit of every enabled byte lane that has one. The bit is set on the same clock edge as the register write.
- R5: A write through either register region drops each enabled byte whose soft lock bit is set and reports `rsp_err`=1. The other enabled bytes of the same access are still written.
- R6: Reads of the register regions are never blocked by lock bits and never report an error.
- R7: In 0x3800–0x3DFF, the byte at lock offset k holds the lock bits of register word k in bits 3:0, with bit i for lane i. Bits 7:4 read 0, and lock bits that are not implemented read 0. A write loads the implemented bits of the low nibble of each enabled byte, so writing 0 clears a bit and writing 1 sets it.
- R8: Bit 0 of the configuration word at 0x3E00 is the hard lock. Writing 1 with lane 0 enabled sets it, writing 0 has no effect, and a read returns it in bit 0 with the other bits 0. Only reset clears it.
- R9: While the hard lock is set, a write to the lock region changes no lock bit and reports `rsp_err`=1.
- R10: After reset, all lock bits and the hard lock are 0 and `rsp_valid` is 0.
- R11: A write response carries read data 0. The other configuration words read 0, ignore writes and report no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 14 | Byte offset inside the window, word aligned |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access refused or partly dropped |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rf_req | output | 1 | Register file access strobe |
| rf_we | output | 1 | Register file write |
| rf_word | output | 11 | Register word index |
| rf_be | output | 4 | Byte enables with locked lanes removed |
| rf_wdata | output | 32 | Register file write data |
| rf_rdata | input | 32 | Register file read data, valid one cycle after a read strobe |

## Verification
The assertions take for granted a few things about the inputs. Offsets are word aligned. The register file returns read data on the cycle after a read strobe. `req_valid` stays low while reset is active. The stimulus keeps to these rules: it draws only word-aligned offsets, it drives the register file from a bench model with exactly one cycle of read latency, and it holds the request idle during both resets. Within those limits, addresses are spread over every region, including register words that have no lock bits and lock bytes beyond the implemented range. The hard lock is kept clear during the first random phase and left free in the second.

// File: rtl/regprot_pkg.sv
package regprot_pkg;

  localparam int unsigned WIN_AW   = 14;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned LANES    = BUS_DW / 8;
  localparam int unsigned RWORD_W  = 11;
  localparam int unsigned LWORD_W  = 9;
  localparam int unsigned CWORD_W  = 7;

  typedef enum logic [2:0] {
    RG_DIRECT,
    RG_HOLE,
    RG_MIRROR,
    RG_LOCK,
    RG_CFG
  } region_e;

  function automatic region_e classify(input logic [WIN_AW-1:0] a);
    region_e r;
    if (!a[13]) begin
      r = (a[12:11] == 2'b11) ? RG_HOLE : RG_DIRECT;
    end else if (a[12:11] != 2'b11) begin
      r = RG_MIRROR;
    end else if (a[10:9] == 2'b11) begin
      r = RG_CFG;
    end else begin
      r = RG_LOCK;
    end
    return r;
  endfunction

endpackage

// File: rtl/regprot_rstsync.sv
module regprot_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/regprot_decode.sv
module regprot_decode
  import regprot_pkg::*;
(
  input  logic [WIN_AW-1:0]  addr,
  output region_e            region,
  output logic [RWORD_W-1:0] reg_word,
  output logic [LWORD_W-1:0] lock_word,
  output logic [CWORD_W-1:0] cfg_word
);

  always_comb begin
    region    = classify(addr);
    reg_word  = addr[12:2];
    lock_word = addr[10:2];
    cfg_word  = addr[8:2];
  end

endmodule

// File: rtl/regprot_lockbank.sv
module regprot_lockbank
  import regprot_pkg::*;
#(
  parameter int unsigned               NUM_LOCK_WORDS = 16,
  parameter logic [4*NUM_LOCK_WORDS-1:0] LOCK_MASK    = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RWORD_W-1:0] look_word,
  output logic [LANES-1:0]   look_lanes,
  input  logic               set_en,
  input  logic [RWORD_W-1:0] set_word,
  input  logic [LANES-1:0]   set_be,
  input  logic               lw_en,
  input  logic [LWORD_W-1:0] lw_word,
  input  logic [LANES-1:0]   lw_be,
  input  logic [BUS_DW-1:0]  lw_data,
  output logic [BUS_DW-1:0]  lr_data,
  input  logic               hard_set,
  output logic               hard_q
);

  localparam int unsigned NBITS = 4 * NUM_LOCK_WORDS;

  logic [NBITS-1:0] lk_q;
  logic             hard_d;
  logic             lw_allowed;

  assign lw_allowed = lw_en && !hard_q;

  // one flop per implemented lock bit; masked-out bits are constant zero
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    localparam int unsigned RW    = b / 4;
    localparam int unsigned LN    = b % 4;
    localparam int unsigned LWORD = RW / 4;
    localparam int unsigned LLANE = RW % 4;
    if (LOCK_MASK[b]) begin : g_impl
      logic hit_lw;
      logic hit_set;
      logic bit_en;
      logic bit_d;
      logic bit_q;

      always_comb begin
        hit_lw  = lw_allowed && (lw_word == LWORD_W'(LWORD)) && lw_be[LLANE];
        hit_set = set_en && (set_word == RWORD_W'(RW)) && set_be[LN];
        bit_en  = hit_lw || hit_set;
        bit_d   = hit_lw ? lw_data[8*LLANE+LN] : 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_en) begin
          bit_q <= bit_d;
        end
      end

      assign lk_q[b] = bit_q;
    end else begin : g_none
      assign lk_q[b] = 1'b0;
    end
  end

  always_comb begin
    look_lanes = '0;
    for (int w = 0; w < int'(NUM_LOCK_WORDS); w++) begin
      if (look_word == RWORD_W'(w)) begin
        look_lanes = lk_q[4*w +: 4];
      end
    end
  end

  always_comb begin
    lr_data = '0;
    for (int j = 0; j < int'(LANES); j++) begin
      for (int w = 0; w < int'(NUM_LOCK_WORDS); w++) begin
        if ({lw_word, 2'(j)} == RWORD_W'(w)) begin
          lr_data[8*j +: 4] = lk_q[4*w +: 4];
        end
      end
    end
  end

  always_comb begin
    hard_d = hard_q || hard_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_q <= 1'b0;
    end else begin
      hard_q <= hard_d;
    end
  end

  logic unused_lw_hi;
  assign unused_lw_hi = ^{lw_data[31:28], lw_data[23:20], lw_data[15:12], lw_data[7:4]};

  // R8: hard lock never drops once set
  a_r8_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |=> hard_q);

  // R9: no lock bit falls while the hard lock holds
  a_r9_no_clear_when_hard: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |=> (($past(lk_q) & ~lk_q) == '0));

  // R4: a mirror write never clears a lock bit
  a_r4_mirror_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !lw_en) |=> (($past(lk_q) & ~lk_q) == '0));

endmodule

// File: rtl/regprot_resp.sv
module regprot_resp
  import regprot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              err_d,
  input  logic              sel_rf_d,
  input  logic [BUS_DW-1:0] loc_d,
  input  logic [BUS_DW-1:0] rf_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_DW-1:0] rsp_rdata
);

  logic              valid_q;
  logic              err_q;
  logic              sel_rf_q;
  logic [BUS_DW-1:0] loc_q;
  logic              err_n;
  logic              sel_rf_n;
  logic [BUS_DW-1:0] loc_n;

  always_comb begin
    err_n    = err_d;
    sel_rf_n = sel_rf_d;
    loc_n    = err_d ? '0 : loc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      sel_rf_q <= 1'b0;
      loc_q    <= '0;
    end else if (req_valid) begin
      err_q    <= err_n;
      sel_rf_q <= sel_rf_n;
      loc_q    <= loc_n;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = valid_q && err_q;
  assign rsp_rdata = !valid_q ? '0 : (sel_rf_q ? rf_rdata : loc_q);

  // R1: one response for each request, one cycle later
  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

endmodule

// File: rtl/regprot_wrap.sv
module regprot_wrap
  import regprot_pkg::*;
#(
  parameter int unsigned                 NUM_LOCK_WORDS = 16,
  parameter logic [4*NUM_LOCK_WORDS-1:0] LOCK_MASK      = 64'hF0FF_3FFF_0FF7_FFFE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [13:0]        req_addr,
  input  logic               req_we,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic               rf_req,
  output logic               rf_we,
  output logic [10:0]        rf_word,
  output logic [3:0]         rf_be,
  output logic [31:0]        rf_wdata,
  input  logic [31:0]        rf_rdata
);

  logic               rst_sync_n;
  region_e            region;
  logic [RWORD_W-1:0] reg_word;
  logic [LWORD_W-1:0] lock_word;
  logic [CWORD_W-1:0] cfg_word;
  logic [LANES-1:0]   look_lanes;
  logic [LANES-1:0]   drop;
  logic [BUS_DW-1:0]  lr_data;
  logic               hard_q;
  logic               is_reg;
  logic               set_en;
  logic               lw_en;
  logic               hard_set;
  logic               err_d;
  logic               sel_rf_d;
  logic [BUS_DW-1:0]  loc_d;

  regprot_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  regprot_decode u_decode (
    .addr      (req_addr),
    .region    (region),
    .reg_word  (reg_word),
    .lock_word (lock_word),
    .cfg_word  (cfg_word)
  );

  always_comb begin
    is_reg   = (region == RG_DIRECT) || (region == RG_MIRROR);
    drop     = req_we ? (req_be & look_lanes) : '0;
    set_en   = req_valid && req_we && (region == RG_MIRROR);
    lw_en    = req_valid && req_we && (region == RG_LOCK);
    hard_set = req_valid && req_we && (region == RG_CFG) && (cfg_word == '0)
               && req_be[0] && req_wdata[0];
    err_d    = (region == RG_HOLE) || (is_reg && (drop != '0))
               || ((region == RG_LOCK) && req_we && hard_q);
    sel_rf_d = is_reg && !req_we;
    loc_d    = '0;
    if (!req_we) begin
      if (region == RG_LOCK) begin
        loc_d = lr_data;
      end else if ((region == RG_CFG) && (cfg_word == '0)) begin
        loc_d = {{(BUS_DW-1){1'b0}}, hard_q};
      end
    end
  end

  regprot_lockbank #(
    .NUM_LOCK_WORDS (NUM_LOCK_WORDS),
    .LOCK_MASK      (LOCK_MASK)
  ) u_lockbank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .look_word  (reg_word),
    .look_lanes (look_lanes),
    .set_en     (set_en),
    .set_word   (reg_word),
    .set_be     (req_be & ~drop),
    .lw_en      (lw_en),
    .lw_word    (lock_word),
    .lw_be      (req_be),
    .lw_data    (req_wdata),
    .lr_data    (lr_data),
    .hard_set   (hard_set),
    .hard_q     (hard_q)
  );

  regprot_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .err_d     (err_d),
    .sel_rf_d  (sel_rf_d),
    .loc_d     (loc_d),
    .rf_rdata  (rf_rdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  assign rf_req   = req_valid && is_reg;
  assign rf_we    = req_we;
  assign rf_word  = reg_word;
  assign rf_be    = req_be & ~drop;
  assign rf_wdata = req_wdata;

  logic unused_addr_lo;
  assign unused_addr_lo = ^req_addr[1:0];

  // R2: the reserved hole never reaches the register file
  a_r2_hole_no_rf: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (req_addr >= 14'h1800) && (req_addr < 14'h2000)) |-> !rf_req);

  // R2: the reserved hole always answers with an error
  a_r2_hole_err: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (req_addr >= 14'h1800) && (req_addr < 14'h2000)) |=> rsp_err);

  // R6: reads carry every requested lane to the register file
  a_r6_read_lanes_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rf_req && !rf_we) |-> (rf_be == req_be));

  // R5: any lane removed from a write is reported next cycle
  a_r5_drop_reported: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rf_req && rf_we && (rf_be != req_be)) |=> rsp_err);

endmodule

// File: tb/test_regprot_wrap.sv
module test_regprot_wrap;

  localparam int          NW   = 16;
  localparam logic [63:0] MASK = 64'hF0FF_3FFF_0FF7_FFFE;
  localparam int          NREG = 1536;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [13:0] req_addr;
  logic        req_we;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        rf_req;
  logic        rf_we;
  logic [10:0] rf_word;
  logic [3:0]  rf_be;
  logic [31:0] rf_wdata;
  logic [31:0] rf_rdata;

  always #5 clk = ~clk;

  regprot_wrap #(.NUM_LOCK_WORDS(NW), .LOCK_MASK(MASK)) i_regprot_wrap (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
    .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .rf_req(rf_req), .rf_we(rf_we), .rf_word(rf_word), .rf_be(rf_be),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // plain-array register file beside the block
  logic [31:0] rf_mem [0:NREG-1];
  always @(posedge clk) begin
    if (rf_req) begin
      if (rf_we) begin
        for (int j = 0; j < 4; j++) begin
          if (rf_be[j]) rf_mem[rf_word][8*j +: 8] <= rf_wdata[8*j +: 8];
        end
      end
      rf_rdata <= rf_mem[rf_word];
    end
  end

  // reference model state
  logic [31:0] exp_mem [0:NREG-1];
  bit          exp_lk  [0:4*NW-1];
  bit          exp_hard;
  bit          p_valid;
  bit          p_err;
  logic [31:0] p_data;
  string       p_tag;
  string       force_tag;
  int          n_vec;
  int          n_bad;
  int          phase;

  task automatic check_prev();
    n_vec++;
    if ((rsp_valid !== p_valid) ||
        (p_valid && ((rsp_err !== p_err) || (rsp_rdata !== p_data)))) begin
      n_bad++;
      $display("FAIL %s: valid/err/rdata actual %b/%b/%h expected %b/%b/%h",
               p_tag, rsp_valid, rsp_err, rsp_rdata, p_valid, p_err, p_data);
    end
  endtask

  task automatic model(input bit v, input logic [13:0] a, input bit we,
                       input logic [3:0] be, input logic [31:0] wd);
    int w;
    int r;
    bit mir;
    bit lk;
    bit anylk;
    bit dropped;
    p_valid = v;
    p_err   = 1'b0;
    p_data  = '0;
    p_tag   = "R1";
    if (v) begin
      if ((a < 14'h1800) || ((a >= 14'h2000) && (a < 14'h3800))) begin
        w = int'(a[12:2]);
        mir = a[13];
        anylk = 1'b0;
        dropped = 1'b0;
        for (int j = 0; j < 4; j++) begin
          lk = (w < NW) && exp_lk[4*w+j];
          anylk |= lk;
          if (we && be[j]) begin
            if (lk) dropped = 1'b1;
            else exp_mem[w][8*j +: 8] = wd[8*j +: 8];
            if (mir && (w < NW) && MASK[4*w+j]) exp_lk[4*w+j] = 1'b1;
          end
        end
        if (we) begin
          p_err = dropped;
          p_tag = dropped ? "R5" : (mir ? "R4" : "R11");
        end else begin
          p_data = exp_mem[w];
          p_tag  = anylk ? "R6" : (mir ? "R3" : "R1");
        end
      end else if (a < 14'h2000) begin
        p_err = 1'b1;
        p_tag = "R2";
      end else if (a < 14'h3E00) begin
        w = int'(a[10:2]);
        if (we) begin
          if (exp_hard) begin
            p_err = 1'b1;
            p_tag = "R9";
          end else begin
            p_tag = "R7";
            for (int j = 0; j < 4; j++) begin
              r = 4*w + j;
              if (be[j] && (r < NW)) begin
                for (int i = 0; i < 4; i++) begin
                  if (MASK[4*r+i]) exp_lk[4*r+i] = wd[8*j+i];
                end
              end
            end
          end
        end else begin
          p_tag = "R7";
          for (int j = 0; j < 4; j++) begin
            r = 4*w + j;
            for (int i = 0; i < 4; i++) begin
              if (r < NW) p_data[8*j+i] = exp_lk[4*r+i];
            end
          end
        end
      end else begin
        w = int'(a[8:2]);
        if (w == 0) begin
          p_tag = "R8";
          if (we && be[0] && wd[0]) exp_hard = 1'b1;
          if (!we) p_data = {31'b0, exp_hard};
        end else begin
          p_tag = "R11";
        end
      end
      if (force_tag != "") p_tag = force_tag;
    end
  endtask

  task automatic step(input bit v, input logic [13:0] a, input bit we,
                      input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    check_prev();
    model(v, a, we, be, wd);
    req_valid = v;
    req_addr  = a;
    req_we    = we;
    req_be    = be;
    req_wdata = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n     = 1'b0;
    p_valid   = 1'b0;
    exp_hard  = 1'b0;
    for (int b = 0; b < 4*NW; b++) exp_lk[b] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: no response right after reset
    n_vec++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: rsp_valid actual %b expected 0", rsp_valid);
    end
  endtask

  function automatic logic [13:0] rnd_addr();
    int sel;
    int w;
    sel = int'($urandom % 10);
    w = int'($urandom % 20);
    if ($urandom % 8 == 0) w = 1500 + int'($urandom % 36);
    case (sel)
      0, 1, 2: return 14'(4*w);
      3, 4, 5: return 14'(16'h2000 + 4*w);
      6:       return 14'(16'h1800 + 4*($urandom % 512));
      7, 8:    return 14'(16'h3800 + 4*($urandom % 6));
      default: return 14'(16'h3E00 + 4*($urandom % 2));
    endcase
  endfunction

  task automatic rnd_run(input int n);
    logic [13:0] a;
    logic [31:0] wd;
    bit we;
    for (int k = 0; k < n; k++) begin
      a  = rnd_addr();
      we = ($urandom % 2) == 1;
      wd = $urandom;
      if ((phase == 1) && (a >= 14'h3E00)) wd[0] = 1'b0;
      step(($urandom % 5) != 0, a, we, 4'($urandom % 16), wd);
    end
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    phase = 1;
    force_tag = "";
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_we = 1'b0;
    req_be = '0;
    req_wdata = '0;
    rf_rdata = '0;
    exp_hard = 1'b0;
    p_valid = 1'b0;
    p_tag = "R10";
    for (int w = 0; w < NREG; w++) begin
      rf_mem[w]  = 32'h5A00_0000 ^ (w * 32'h0001_0203);
      exp_mem[w] = 32'h5A00_0000 ^ (w * 32'h0001_0203);
    end
    for (int b = 0; b < 4*NW; b++) exp_lk[b] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state of the response and of the lock/config registers
    force_tag = "R10";
    step(1, 14'h3800, 0, 4'hF, 0);
    step(1, 14'h3804, 0, 4'hF, 0);
    step(1, 14'h3E00, 0, 4'hF, 0);
    force_tag = "";
    step(1, 14'h0008, 1, 4'hF, 32'hA5A5_1234);  // R11 direct write
    step(1, 14'h0008, 0, 4'hF, 0);              // R1 read back
    step(1, 14'h2008, 0, 4'hF, 0);              // R3 mirror read
    step(1, 14'h200C, 1, 4'hF, 32'h1122_3344);  // R4 mirror write arms locks
    step(1, 14'h000C, 1, 4'h3, 32'hFFFF_FFFF);  // R5 dropped
    step(1, 14'h000C, 0, 4'hF, 0);              // R6 read of locked word
    step(1, 14'h3800, 0, 4'hF, 0);              // R7 nibble layout
    step(1, 14'h3800, 1, 4'h8, 32'h0000_0000);  // R7 clear word 3
    step(1, 14'h000C, 1, 4'hF, 32'hCAFE_BABE);  // written now
    step(1, 14'h000C, 0, 4'hF, 0);
    step(1, 14'h0004, 1, 4'h1, 32'h0000_00EE);  // R5 partial: lane 0 of word 1
    step(1, 14'h2004, 1, 4'h3, 32'h0000_1111);
    step(1, 14'h0004, 1, 4'h7, 32'h0022_3344);  // R5 lanes 0,1 drop, lane 2 lands
    step(1, 14'h0004, 0, 4'hF, 0);
    step(1, 14'h1804, 1, 4'hF, 32'hDEAD_BEEF);  // R2 hole write
    step(1, 14'h1FFC, 0, 4'hF, 0);              // R2 hole read
    step(1, 14'h3E04, 1, 4'hF, 32'hFFFF_FFFF);  // R11 other config word
    step(1, 14'h3E04, 0, 4'hF, 0);
    step(1, 14'h3E00, 1, 4'hF, 32'h0);          // R8 writing 0 no effect
    step(1, 14'h3E00, 0, 4'hF, 0);
    step(0, 14'h0, 0, 4'h0, 0);                 // R1 idle cycle
    rnd_run(3000);
    phase = 2;
    step(1, 14'h3800, 1, 4'hF, 32'h0F0F_0F0F);  // R7 set all
    step(1, 14'h3E00, 1, 4'h1, 32'h1);          // R8 set hard lock
    step(1, 14'h3E00, 0, 4'hF, 0);
    step(1, 14'h3800, 1, 4'hF, 32'h0);          // R9 refused
    step(1, 14'h3800, 0, 4'hF, 0);
    rnd_run(1500);
    do_reset();
    force_tag = "R10";
    step(1, 14'h3800, 0, 4'hF, 0);
    step(1, 14'h3804, 0, 4'hF, 0);
    step(1, 14'h3E00, 0, 4'hF, 0);
    force_tag = "";
    step(1, 14'h000C, 0, 4'hF, 0);              // R1 registers keep contents
    step(0, 14'h0, 0, 4'h0, 0);
    step(0, 14'h0, 0, 4'h0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1: watchdog cycles actual 200000 expected fewer");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule